// File: doc/BRIEF.md
# Reload Down-Counter Timer with Bus Registers

This block is a 32-bit down-counting timer that sits on an APB slave port. Software loads a start value and a reload value, picks what advances the count, and turns on the run bit. Each tick takes one off the count. When the count steps from one to zero, the timer can latch an interrupt flag. The count then stays at zero for one more tick before it picks up the reload value. The flag drives a level interrupt line until software clears it.

A tick can come from three sources. It can occur on every PCLK cycle. It can occur on every PCLK cycle while an external input is high, so the input acts as a gate. It can occur once for each rising edge of that external input, so the input acts as a slow count clock. The external input passes through a two-flop synchroniser before any of this logic uses it. A bank of read-only identification words near the top of the 4 KiB window lets software recognise the block.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset the control, count, reload and status registers all read 0, and `irq_o` is low.
- R2: Register map by byte offset:
  - 0x0 is control.
  - 0x4 is the current count.
  - 0x8 is reload.
  - 0xC is status.
  - Control bit 0 runs the timer, bit 1 selects gate mode, bit 2 selects external-clock mode and bit 3 enables the interrupt.
  - Only control bits [3:0] are kept, and bits [31:4] read as 0.
- R3: A tick that takes the count from 1 to 0 is an expiry. The next tick leaves the count at the reload value, so the count stays at 0 for exactly one tick.
- R4: When the reload value is 0, the count stays at 0 on later ticks and no further interrupt is raised.
- R5: An expiry sets status bit 0 only when control bit 3 is 1. `irq_o` follows that stored bit, and reading offset 0xC returns it in bit 0.
- R6: The status bit is sticky. Writing 1 to bit 0 of offset 0xC clears it. Writing 0 leaves it unchanged.
- R7: A write to offset 0x8 sets both the reload value and the count. A write to offset 0x4 sets only the count.
- R8: While control bit 0 is 0, the count does not change. In gate mode the count takes one step per PCLK cycle while the synchronised external input is high, and none while it is low.
- R9: In external-clock mode the count takes one step for each synchronised rising edge of the external input. This mode wins when bits 1 and 2 are both set.
- R10: A bus write to offset 0x4 or 0x8 in the same cycle as a tick wins over the decrement.
- R11: The identification words at 0xFD0 through 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored. Reads from unmapped or unaligned offsets return 0.
- R12: The slave adds no wait states and gives no error response: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response, tied low |
| ext_in | input | 1 | Asynchronous external gate or count clock |
| irq_o | output | 1 | Level interrupt, equal to the status bit |

## Verification
Register and count writes take effect at the clock edge that ends the access phase, and a free-running tick at that same edge is overridden by the write. The following cycle then counts again. In free-run mode the interrupt is due at the third rising edge after the enabling write, for a start value of 3. The bench counts those edges and samples on the falling edge in between. Any change on the external input reaches the count two edges later because of the synchroniser. The bench therefore holds each pulse for three cycles and lets the input settle for four cycles before it reads back, so each pulse makes exactly one step.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  // Word indices (byte offset >> 2) of the control and data registers
  localparam int unsigned WIDX_CTRL   = 0;
  localparam int unsigned WIDX_COUNT  = 1;
  localparam int unsigned WIDX_RELOAD = 2;
  localparam int unsigned WIDX_STAT   = 3;

  // Identification bank: 0xFD0 .. 0xFFC
  localparam int unsigned WIDX_ID_FIRST = 32'h3F4;
  localparam int unsigned ID_WORDS      = 12;
  localparam int unsigned CTRL_BITS     = 4;

  // Control layout: bit 0 run, bit 1 gate, bit 2 external clock, bit 3 irq enable
  typedef struct packed {
    logic irq_en;
    logic ext_clk;
    logic ext_gate;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input int unsigned k);
    logic [7:0] b;
    case (k)
      0:       b = 8'h04;
      4:       b = 8'h22;
      5:       b = 8'hB8;
      6:       b = 8'h1B;
      8:       b = 8'h0D;
      9:       b = 8'hF0;
      10:      b = 8'h05;
      11:      b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rdt_ext_sync.sv
module rdt_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic pclk,
  input  logic presetn,
  input  logic ext_in,
  input  logic run,
  input  logic gate_mode,
  input  logic clk_mode,
  output logic ext_level,
  output logic ext_rise,
  output logic tick
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge pclk or negedge presetn) begin
          if (!presetn) chain_q[0] <= 1'b0;
          else          chain_q[0] <= ext_in;
        end
      end else begin : g_next
        always_ff @(posedge pclk or negedge presetn) begin
          if (!presetn) chain_q[g] <= 1'b0;
          else          chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) last_q <= 1'b0;
    else          last_q <= chain_q[STAGES-1];
  end

  assign ext_level = chain_q[STAGES-1];
  assign ext_rise  = ext_level & ~last_q;

  // External-clock mode outranks gate mode
  always_comb begin
    if (!run)           tick = 1'b0;
    else if (clk_mode)  tick = ext_rise;
    else if (gate_mode) tick = ext_level;
    else                tick = 1'b1;
  end

endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Step rule: zero picks up the reload value, anything else decrements
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - ONE;
  endfunction

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)  count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= step(count_q, reload);
  end

  assign count  = count_q;
  assign expire = tick & ~load & (count_q == ONE);

endmodule

// File: rtl/rdt_regfile.sv
module rdt_regfile import rdt_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output logic [DATA_W-1:0] prdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              irq,
  output logic              load
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [31:0]      widx;
  logic             aligned;
  logic             wr;
  logic             hit_ctrl, hit_count, hit_reload, hit_stat, hit_id;
  logic             clr_req;
  ctrl_t            ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic              stat_q;
  logic [DATA_W-1:0] rd_mux;

  assign idx     = paddr[ADDR_W-1:2];
  assign widx    = 32'(idx);
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel & penable & pwrite & aligned;

  assign hit_ctrl   = aligned & (widx == WIDX_CTRL);
  assign hit_count  = aligned & (widx == WIDX_COUNT);
  assign hit_reload = aligned & (widx == WIDX_RELOAD);
  assign hit_stat   = aligned & (widx == WIDX_STAT);
  assign hit_id     = aligned & (widx >= WIDX_ID_FIRST) & (widx < WIDX_ID_FIRST + ID_WORDS);

  assign load    = wr & (hit_count | hit_reload);
  assign clr_req = wr & hit_stat & pwdata[0];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr && hit_ctrl)   ctrl_q   <= ctrl_t'(pwdata[CTRL_BITS-1:0]);
      if (wr && hit_reload) reload_q <= pwdata;
    end
  end

  // Expiry outranks a same-cycle clear so no event is lost
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                     stat_q <= 1'b0;
    else if (expire && ctrl_q.irq_en) stat_q <= 1'b1;
    else if (clr_req)                 stat_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)        rd_mux = DATA_W'(ctrl_q);
    else if (hit_count)  rd_mux = count;
    else if (hit_reload) rd_mux = reload_q;
    else if (hit_stat)   rd_mux = DATA_W'(stat_q);
    else if (hit_id)     rd_mux = DATA_W'(id_byte(widx - WIDX_ID_FIRST));
  end

  assign prdata = (psel && !pwrite) ? rd_mux : '0;
  assign ctrl   = ctrl_q;
  assign reload = reload_q;
  assign irq    = stat_q;

endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer import rdt_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq_o
);

  ctrl_t             ctrl_w;
  logic [DATA_W-1:0] reload_w;
  logic [DATA_W-1:0] count_w;
  logic              load_w;
  logic              tick_w;
  logic              expire_w;
  logic              ext_level_w;
  logic              ext_rise_w;
  logic              irq_en_w;

  assign irq_en_w = ctrl_w.irq_en;

  rdt_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .pclk      (pclk),
    .presetn   (presetn),
    .ext_in    (ext_in),
    .run       (ctrl_w.run),
    .gate_mode (ctrl_w.ext_gate),
    .clk_mode  (ctrl_w.ext_clk),
    .ext_level (ext_level_w),
    .ext_rise  (ext_rise_w),
    .tick      (tick_w)
  );

  rdt_counter #(.CNT_W(DATA_W)) u_counter (
    .pclk     (pclk),
    .presetn  (presetn),
    .tick     (tick_w),
    .load     (load_w),
    .load_val (pwdata),
    .reload   (reload_w),
    .count    (count_w),
    .expire   (expire_w)
  );

  rdt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .count   (count_w),
    .expire  (expire_w),
    .prdata  (prdata),
    .ctrl    (ctrl_w),
    .reload  (reload_w),
    .irq     (irq_o),
    .load    (load_w)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              irq_o,
  input logic              tick,
  input logic              irq_en,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reload
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic acc_wr, wr_count, wr_reload, wr_any, wr_clear, rd_ctrl;
  assign acc_wr    = psel && penable && pwrite && (paddr[1:0] == 2'b00);
  assign wr_count  = acc_wr && (paddr[ADDR_W-1:2] == 1);
  assign wr_reload = acc_wr && (paddr[ADDR_W-1:2] == 2);
  assign wr_any    = wr_count || wr_reload;
  assign wr_clear  = acc_wr && (paddr[ADDR_W-1:2] == 3) && pwdata[0];
  assign rd_ctrl   = psel && !pwrite && (paddr == '0);

  AST_LINK_CLEAN: assert property (@(posedge pclk) disable iff (!presetn) pready && !pslverr); // R12
  AST_CTRL_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn) rd_ctrl |-> (prdata[DATA_W-1:4] == '0)); // R2
  AST_STEP_DOWN: assert property (@(posedge pclk) disable iff (!presetn) (tick && !wr_any && count != '0) |=> (count == $past(count) - ONE)); // R3
  AST_HOLD_THEN_RELOAD: assert property (@(posedge pclk) disable iff (!presetn) (tick && !wr_any && count == '0) |=> (count == $past(reload))); // R3
  AST_ZERO_RELOAD_QUIET: assert property (@(posedge pclk) disable iff (!presetn) (count == '0 && reload == '0 && !wr_any && !irq_o) |=> !irq_o); // R4
  AST_IRQ_ON_EXPIRY: assert property (@(posedge pclk) disable iff (!presetn) (tick && !wr_any && count == ONE && irq_en) |=> irq_o); // R5
  AST_IRQ_HAS_CAUSE: assert property (@(posedge pclk) disable iff (!presetn) $rose(irq_o) |-> $past(tick && !wr_any && count == ONE && irq_en)); // R5
  AST_IRQ_CLEARED: assert property (@(posedge pclk) disable iff (!presetn) (wr_clear && !(tick && !wr_any && count == ONE && irq_en)) |=> !irq_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge pclk) disable iff (!presetn) (irq_o && !wr_clear) |=> irq_o); // R6
  AST_RELOAD_WR_BOTH: assert property (@(posedge pclk) disable iff (!presetn) wr_reload |=> (count == $past(pwdata) && reload == $past(pwdata))); // R7
  AST_COUNT_WR_WINS: assert property (@(posedge pclk) disable iff (!presetn) wr_count |=> (count == $past(pwdata))); // R10
  AST_IDLE_STABLE: assert property (@(posedge pclk) disable iff (!presetn) (!tick && !wr_any) |=> $stable(count)); // R8

endmodule

bind apb_reload_timer rdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdt_checker (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr),
  .irq_o   (irq_o),
  .tick    (tick_w),
  .irq_en  (irq_en_w),
  .count   (count_w),
  .reload  (reload_w)
);

// File: tb/apb_reload_timer_tb.sv
`timescale 1ns/1ps
module apb_reload_timer_tb;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        ext_in = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_CTRL = 12'h000, A_CNT = 12'h004, A_RLD = 12'h008, A_STAT = 12'h00C;

  always #4 pclk = ~pclk;

  apb_reload_timer u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ext_in(ext_in), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All bus tasks start and finish just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge pclk); @(negedge pclk);
    penable = 1'b1;
    @(posedge pclk); @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(posedge pclk); @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge pclk); @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse();
    ext_in = 1'b1;
    repeat (3) @(posedge pclk);
    @(negedge pclk) ext_in = 1'b0;
    repeat (4) @(posedge pclk);
    @(negedge pclk);
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
    rd_chk("R1 reload", A_RLD, 32'h0);
    rd_chk("R1 status", A_STAT, 32'h0);
  endtask

  task automatic t_ids();
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8, 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) rd_chk("R11 id word", 12'hFD0 + 12'(4 * i), {24'b0, exp[i]});
    wr(12'hFE0, 32'hFFFF_FFFF);
    rd_chk("R11 id write ignored", 12'hFE0, 32'h22);
    rd_chk("R11 unmapped", 12'h010, 32'h0);
    rd_chk("R11 unaligned", 12'h006, 32'h0);
  endtask

  task automatic t_link();
    psel = 1'b1; pwrite = 1'b0; paddr = A_CTRL;
    @(posedge pclk); @(negedge pclk);
    penable = 1'b1;
    #1 chk("R12 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    @(posedge pclk); @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_ctrl_mask();
    wr(A_CTRL, 32'hFFFF_FFF6);
    rd_chk("R2 ctrl kept bits", A_CTRL, 32'h6);
    wr(A_CTRL, 32'hFFFF_FFF0);
    rd_chk("R2 ctrl upper dropped", A_CTRL, 32'h0);
  endtask

  task automatic t_load_regs();
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'h1234_5678);
    rd_chk("R7 reload sets count", A_CNT, 32'h1234_5678);
    rd_chk("R7 reload reg", A_RLD, 32'h1234_5678);
    wr(A_CNT, 32'h9);
    rd_chk("R7 count write", A_CNT, 32'h9);
    rd_chk("R7 count write keeps reload", A_RLD, 32'h1234_5678);
  endtask

  task automatic t_free_run();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
    wr(A_RLD, 32'd3);
    wr(A_CTRL, 32'h9);            // ticks begin at the next edge: 2, 1, 0
    repeat (2) @(posedge pclk);
    @(negedge pclk);
    chk("R5 irq not yet", {31'b0, irq_o}, 32'h0);
    @(posedge pclk); @(negedge pclk);
    chk("R5 irq on 1->0", {31'b0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h8);            // two more ticks: 0->3, 3->2
    rd_chk("R3 reloaded then stepped", A_CNT, 32'd2);
    repeat (5) @(posedge pclk);
    @(negedge pclk);
    rd_chk("R8 stopped holds", A_CNT, 32'd2);
    chk("R6 sticky", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0);
    chk("R6 write 0 no effect", {31'b0, irq_o}, 32'h1);
    rd_chk("R5 status read", A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    chk("R6 write 1 clears", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_clock_hold();
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd2);
    wr(A_CTRL, 32'hD);
    pulse();
    rd_chk("R9 one step per edge", A_CNT, 32'd1);
    chk("R3 no irq at 1", {31'b0, irq_o}, 32'h0);
    pulse();
    rd_chk("R3 reaches zero", A_CNT, 32'd0);
    chk("R5 irq in clock mode", {31'b0, irq_o}, 32'h1);
    pulse();
    rd_chk("R3 reload after hold", A_CNT, 32'd2);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_zero_reload();
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd0);
    wr(A_STAT, 32'h1);
    wr(A_CTRL, 32'hD);
    for (int i = 0; i < 3; i++) pulse();
    rd_chk("R4 stays zero", A_CNT, 32'd0);
    chk("R4 no irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_irq_disabled();
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd5);
    wr(A_CNT, 32'd1);
    wr(A_CTRL, 32'h5);
    pulse();
    rd_chk("R5 expiry counted", A_CNT, 32'd0);
    rd_chk("R5 no status when disabled", A_STAT, 32'h0);
    pulse();
    rd_chk("R3 reload with irq off", A_CNT, 32'd5);
  endtask

  task automatic t_gate();
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CTRL, 32'h3);
    repeat (10) @(posedge pclk);
    @(negedge pclk);
    rd_chk("R8 gate low holds", A_CNT, 32'd100);
    ext_in = 1'b1;
    repeat (20) @(posedge pclk);
    @(negedge pclk) ext_in = 1'b0;
    repeat (6) @(posedge pclk);
    @(negedge pclk);
    rd_chk("R8 gate high counts per cycle", A_CNT, 32'd80);
  endtask

  task automatic t_both_modes();
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd50);
    wr(A_CTRL, 32'h7);
    ext_in = 1'b1;
    repeat (10) @(posedge pclk);
    @(negedge pclk) ext_in = 1'b0;
    repeat (5) @(posedge pclk);
    @(negedge pclk);
    rd_chk("R9 clock mode wins", A_CNT, 32'd49);
  endtask

  task automatic t_write_wins();
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd10);
    wr(A_CTRL, 32'h1);
    wr(A_CNT, 32'd1000);          // one tick after commit before the read samples
    rd_chk("R10 write beats tick", A_CNT, 32'd999);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    @(negedge pclk) presetn = 1'b1;
    @(negedge pclk);
    t_reset();
    t_ids();
    t_link();
    t_ctrl_mask();
    t_load_regs();
    t_free_run();
    t_clock_hold();
    t_zero_reload();
    t_irq_disabled();
    t_gate();
    t_both_modes();
    t_write_wins();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule